// File: doc/BRIEF.md
# Four-Channel Converter Serial Host

This block is the synchronous master for an external four-input successive-approximation converter that talks over a 16-clock serial frame. A single start request makes the host pull its active-low select line down. That falling edge starts a conversion in the converter and also opens the frame. The host then runs the serial clock for exactly sixteen periods. The serial clock also drives the converter's conversion, so it must not stop mid-frame. During those periods the host shifts out a control word naming the input address and the input configuration, and it shifts in the 16-bit result.

The returned frame is decoded into four fields: a leading marker bit, a 2-bit channel tag, a sign bit and a 12-bit magnitude. The marker must be zero. The tag is compared with the address that was requested one frame earlier, because the converter reports the channel it was set up for before the current word. The decoded fields appear together with a one-cycle done pulse. A guard interval keeps the select line high before the next frame may begin. The serial clock is derived from the system clock, and each of its phases lasts `DIV` system cycles (`DIV` ≥ 2).

Top module: `adc_serial_host`

## Requirements
- R1: While reset is high and afterwards until the first accepted start, cs_n_o and sclk_o are 1, and busy_o, done_o and din_o are 0.
- R2: A start_i seen while busy_o is 0 is accepted. In the next cycle cs_n_o is 0 and busy_o is 1. busy_o stays 1 until the guard interval after the frame ends.
- R3: Every frame has exactly 16 falling edges of sclk_o, and each low phase of sclk_o lasts DIV system cycles. sclk_o is 1 in every cycle where cs_n_o is 1.
- R4: The control word goes out MSB first on din_o. Its layout is: bit 15 = 1 (write), bits 14:13 = chan_i, bits 12:11 = mode_i, bits 10:0 = parameter CTRL_TAIL. Bit k is driven from the rising sclk edge before falling edge k and is stable across that falling edge.
- R5: dout_i is sampled once at the end of each low phase of sclk_o, which gives 16 bits MSB first. Bit 15 is the leading marker, bits 14:13 the channel tag, bit 12 the sign and bits 11:0 the magnitude. These are presented on res_chan_o, res_sign_o and res_data_o.
- R6: done_o is a single-cycle pulse in the first cycle after the final rising sclk edge, with cs_n_o already 1. The result outputs hold their values until the next done_o.
- R7: frame_err_o is 1 for a frame whose leading marker bit is 1, and 0 otherwise.
- R8: chan_mis_o is 1 when the received tag differs from the chan_i accepted with the previous frame (0 before any frame), and 0 otherwise.
- R9: Between two frames, cs_n_o stays 1 for at least 2*DIV system cycles.
- R10: start_i seen while busy_o is 1 has no effect. No extra frame starts, and the address it carries is neither sent nor used as the next tag expectation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion frame |
| chan_i | input | 2 | Input address to program |
| mode_i | input | 2 | Input configuration to program |
| busy_o | output | 1 | Frame or guard interval in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| res_chan_o | output | 2 | Received channel tag |
| res_sign_o | output | 1 | Received sign bit |
| res_data_o | output | 12 | Received magnitude |
| frame_err_o | output | 1 | Leading marker bit was not zero |
| chan_mis_o | output | 1 | Tag differs from the previously requested address |
| cs_n_o | output | 1 | Active-low select / conversion start |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Control word to the converter |
| dout_i | input | 1 | Result bits from the converter |

## Verification
A wrong phase counter shows up within one serial clock period as a low phase of the wrong length or a wrong count of falling edges at the frame's close. A transmit or receive shift register that is off by one bit corrupts the command word captured by the converter model, or the decoded fields at the very next done_o. A stale tag expectation is caught one frame later through chan_mis_o. A sequencer that takes a start while busy shows up as an extra select fall, or as a changed command word in that same frame.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_W     = 12;
    localparam int TAG_W      = 2;
    localparam int MODE_W     = 2;
    localparam int TAIL_W     = FRAME_BITS - 1 - TAG_W - MODE_W;
    localparam int HALVES     = 2 * FRAME_BITS;
    localparam int HALF_W     = $clog2(HALVES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    // Result frame, MSB first on the wire
    typedef struct packed {
        logic              lead;
        logic [TAG_W-1:0]  tag;
        logic              sign;
        logic [DATA_W-1:0] mag;
    } rx_frame_t;

    // Outgoing control word, MSB first on the wire
    typedef struct packed {
        logic              wr;
        logic [TAG_W-1:0]  addr;
        logic [MODE_W-1:0] mode;
        logic [TAIL_W-1:0] tail;
    } ctrl_word_t;

    function automatic ctrl_word_t make_ctrl(input logic [TAG_W-1:0]  a,
                                             input logic [MODE_W-1:0] m,
                                             input logic [TAIL_W-1:0] t);
        ctrl_word_t w;
        w.wr   = 1'b1;
        w.addr = a;
        w.mode = m;
        w.tail = t;
        return w;
    endfunction

    function automatic logic [FRAME_BITS-1:0] shift_in(input logic [FRAME_BITS-1:0] s,
                                                       input logic b);
        return {s[FRAME_BITS-2:0], b};
    endfunction

endpackage

// File: rtl/adc_clk_phase.sv
module adc_clk_phase
    import adc_host_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic load,
    output logic half_end,
    output logic low_phase,
    output logic last_half
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(DIV - 1);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALVES - 1);

    logic [DIV_W-1:0]  div_q;
    logic [HALF_W-1:0] half_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            div_q  <= '0;
            half_q <= '0;
        end else if (run) begin
            if (div_q == DIV_LAST) begin
                div_q  <= '0;
                half_q <= half_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign half_end  = run && (div_q == DIV_LAST);
    assign low_phase = half_q[0];
    assign last_half = (half_q == HALF_LAST);

    // R3: the phase divider never leaves its range
    a_r3_div_range: assert property (@(posedge clk) disable iff (rst)
        div_q <= DIV_LAST);

    // R3: a phase only advances at the end of a full divided interval
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !half_end) |=> $stable(half_q));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_host_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TAG_W-1:0] chan,
    input  logic             half_end,
    input  logic             last_half,
    output logic             xfer,
    output logic             load,
    output logic             frame_end,
    output logic             busy,
    output logic [TAG_W-1:0] expect_tag
);
    localparam int GAP_LEN = 2 * DIV;
    localparam int GAP_W   = $clog2(GAP_LEN + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_LEN - 1);

    seq_state_e       state_q;
    logic [GAP_W-1:0] gap_q;
    logic [TAG_W-1:0] last_req_q;
    logic [TAG_W-1:0] expect_q;

    assign xfer       = (state_q == ST_XFER);
    assign busy       = (state_q != ST_IDLE);
    assign load       = (state_q == ST_IDLE) && start;
    assign frame_end  = xfer && half_end && last_half;
    assign expect_tag = expect_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            gap_q      <= '0;
            last_req_q <= '0;
            expect_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q    <= ST_XFER;
                        expect_q   <= last_req_q;
                        last_req_q <= chan;
                    end
                end
                ST_XFER: begin
                    if (frame_end) begin
                        state_q <= ST_GAP;
                        gap_q   <= '0;
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_LAST) begin
                        state_q <= ST_IDLE;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: an idle start opens a frame in the next cycle
    a_r2_start_opens: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> xfer);

    // R10: a start during activity never re-enters the transfer from idle
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !xfer) |=> !xfer);

endmodule

// File: rtl/adc_shift_path.sv
module adc_shift_path
    import adc_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  ctrl_word_t       ctrl,
    input  logic             shift_en,
    input  logic             sample_en,
    input  logic             frame_end,
    input  logic             dout,
    input  logic [TAG_W-1:0] expect_tag,
    output logic             tx_msb,
    output logic             done,
    output rx_frame_t        result,
    output logic             frame_err,
    output logic             mismatch
);
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    rx_frame_t             res_q;
    rx_frame_t             fr_next;
    logic                  done_q;
    logic                  err_q;
    logic                  mis_q;

    assign fr_next = rx_frame_t'(shift_in(rx_q, dout));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= ctrl;
            rx_q <= '0;
        end else begin
            if (shift_en) begin
                tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
            end
            if (sample_en) begin
                rx_q <= shift_in(rx_q, dout);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            err_q  <= 1'b0;
            mis_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= frame_end;
            if (frame_end) begin
                res_q <= fr_next;
                err_q <= fr_next.lead;
                mis_q <= (fr_next.tag != expect_tag);
            end
        end
    end

    assign tx_msb    = tx_q[FRAME_BITS-1];
    assign done      = done_q;
    assign result    = res_q;
    assign frame_err = err_q;
    assign mismatch  = mis_q;

    // R6: done lasts a single cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: result fields are held between done pulses
    a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(result) && $stable(frame_err) && $stable(mismatch)));

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int                DIV       = 4,
    parameter logic [TAIL_W-1:0] CTRL_TAIL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [TAG_W-1:0]  chan_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [TAG_W-1:0]  res_chan_o,
    output logic              res_sign_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              frame_err_o,
    output logic              chan_mis_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              din_o,
    input  logic              dout_i
);
    generate
        if (DIV < 2) begin : g_div_check
            $error("DIV must be at least 2");
        end
    endgenerate

    logic             xfer;
    logic             load;
    logic             frame_end;
    logic             half_end;
    logic             low_phase;
    logic             last_half;
    logic             tx_msb;
    logic [TAG_W-1:0] expect_tag;
    logic             shift_en;
    logic             sample_en;
    rx_frame_t        result;
    ctrl_word_t       ctrl;

    assign ctrl = make_ctrl(chan_i, mode_i, CTRL_TAIL);

    adc_seq_fsm #(.DIV(DIV)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .chan       (chan_i),
        .half_end   (half_end),
        .last_half  (last_half),
        .xfer       (xfer),
        .load       (load),
        .frame_end  (frame_end),
        .busy       (busy_o),
        .expect_tag (expect_tag)
    );

    adc_clk_phase #(.DIV(DIV)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (xfer),
        .load      (load),
        .half_end  (half_end),
        .low_phase (low_phase),
        .last_half (last_half)
    );

    // Low phase ends with a rising sclk edge: sample there, and advance the
    // outgoing word for the next falling edge (not after the final phase).
    assign sample_en = half_end && low_phase;
    assign shift_en  = half_end && low_phase && !last_half;

    adc_shift_path u_path (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .ctrl       (ctrl),
        .shift_en   (shift_en),
        .sample_en  (sample_en),
        .frame_end  (frame_end),
        .dout       (dout_i),
        .expect_tag (expect_tag),
        .tx_msb     (tx_msb),
        .done       (done_o),
        .result     (result),
        .frame_err  (frame_err_o),
        .mismatch   (chan_mis_o)
    );

    assign cs_n_o     = !xfer;
    assign sclk_o     = !(xfer && low_phase);
    assign din_o      = xfer && tx_msb;
    assign res_chan_o = result.tag;
    assign res_sign_o = result.sign;
    assign res_data_o = result.mag;

    // R3: sclk only falls inside an open frame
    a_r3_fall_in_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> !cs_n_o);

    // R4: the control bit does not move across a falling sclk edge
    a_r4_din_stable: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> $stable(din_o));

    // R6: done arrives with select already released
    a_r6_done_closed: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cs_n_o && busy_o));

    // R9: select stays released for more than one cycle after a frame
    a_r9_guard: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |=> cs_n_o);

endmodule

// File: tb/sim_adc_serial_host.sv
module sim_adc_serial_host;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam logic [10:0] TAIL = 11'h5A3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  chan_i = 2'd0;
    logic [1:0]  mode_i = 2'd0;
    logic        busy_o, done_o, res_sign_o, frame_err_o, chan_mis_o;
    logic [1:0]  res_chan_o;
    logic [11:0] res_data_o;
    logic        cs_n_o, sclk_o, din_o;
    logic        dout_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_host #(.DIV(DIV), .CTRL_TAIL(TAIL)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .mode_i(mode_i),
        .busy_o(busy_o), .done_o(done_o), .res_chan_o(res_chan_o),
        .res_sign_o(res_sign_o), .res_data_o(res_data_o),
        .frame_err_o(frame_err_o), .chan_mis_o(chan_mis_o),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .din_o(din_o), .dout_i(dout_i)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Converter model: result bit j appears after falling edge j; control bits captured on falls
    logic [15:0] resp_word = '0;
    logic [15:0] cmd_cap   = '0;
    int          bit_idx   = 0;

    always @(negedge cs_n_o) begin
        bit_idx = 0;
        dout_i  = 1'b1;
    end

    always @(negedge sclk_o) begin
        cmd_cap = {cmd_cap[14:0], din_o};
        if (bit_idx < 16) dout_i = resp_word[15 - bit_idx];
        bit_idx++;
    end

    // Port monitors
    int  falls = 0;
    int  low_run = 0;
    int  cs_high_run = 0;
    int  cs_falls = 0;
    bit  prev_sclk = 1'b1;
    bit  prev_cs = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_sclk && !sclk_o) falls++;
            if (!sclk_o) low_run++;
            if (!prev_sclk && sclk_o) begin
                check(low_run == DIV, "R3 low phase length", low_run, DIV);
                low_run = 0;
            end
            if (cs_n_o) begin
                check(sclk_o == 1'b1, "R3 sclk idles high", sclk_o, 1);
                cs_high_run++;
            end
            if (prev_cs && !cs_n_o) begin
                if (cs_falls > 0)
                    check(cs_high_run >= 2*DIV, "R9 guard interval", cs_high_run, 2*DIV);
                cs_falls++;
                falls = 0;
                cs_high_run = 0;
            end
        end
        prev_sclk = sclk_o;
        prev_cs   = cs_n_o;
    end

    logic [1:0] prev_req = 2'd0;
    int         frames_issued = 0;

    task automatic run_frame(input int c, input int m, input int i);
        bit          lead, sign, mis;
        logic [1:0]  tag;
        logic [11:0] data;
        logic [15:0] exp_cmd;
        int          n;
        mis  = (i % 5 == 3);
        lead = (i % 7 == 4);
        sign = i[0];
        tag  = mis ? (prev_req ^ 2'd1) : prev_req;
        if (i == 0)                data = 12'h000;
        else if (m == 3 && c == 2) data = 12'hFFF;
        else                       data = 12'((i * 397 + c * 53 + m) & 32'hFFF);
        resp_word = {lead, tag, sign, data};
        exp_cmd   = {1'b1, 2'(c), 2'(m), TAIL};

        @(negedge clk);
        start_i = 1'b1; chan_i = 2'(c); mode_i = 2'(m);
        @(negedge clk);
        start_i = 1'b0;
        frames_issued++;
        check(cs_n_o == 1'b0, "R2 select low after start", cs_n_o, 0);
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);

        if (i == 10) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1; chan_i = 2'(c) ^ 2'd2;
            @(negedge clk);
            start_i = 1'b0;
        end

        n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done_o == 1'b1, "R6 done pulse", done_o, 1);
        check(cs_n_o == 1'b1, "R6 select released at done", cs_n_o, 1);
        check(falls == 16, "R3 falling edges per frame", falls, 16);
        check(cmd_cap == exp_cmd, "R4 control word", cmd_cap, exp_cmd);
        check(res_data_o == data, "R5 magnitude", res_data_o, data);
        check(res_sign_o == sign, "R5 sign", res_sign_o, sign);
        check(res_chan_o == tag, "R5 tag", res_chan_o, tag);
        check(frame_err_o == lead, "R7 framing flag", frame_err_o, lead);
        check(chan_mis_o == mis, "R8 tag mismatch flag", chan_mis_o, mis);
        @(negedge clk);
        check(done_o == 1'b0, "R6 done single cycle", done_o, 0);
        check(res_data_o == data && res_chan_o == tag, "R6 result held",
              {res_chan_o, res_data_o}, {tag, data});
        prev_req = 2'(c);
        n = 0;
        while (busy_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(cs_n_o == 1'b1, "R2 busy spans guard", cs_n_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n_o == 1 && sclk_o == 1, "R1 reset lines", {cs_n_o, sclk_o}, 2'b11);
        check(busy_o == 0 && done_o == 0 && din_o == 0, "R1 reset status",
              {busy_o, done_o, din_o}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(cs_n_o == 1 && sclk_o == 1 && busy_o == 0 && done_o == 0, "R1 idle after reset",
              {cs_n_o, sclk_o, busy_o, done_o}, 4'b1100);
        begin
            int i = 0;
            for (int c = 0; c < 4; c++)
                for (int m = 0; m < 4; m++)
                    for (int p = 0; p < 3; p++) begin
                        run_frame(c, m, i);
                        i++;
                    end
        end
        repeat (10) @(negedge clk);
        check(cs_falls == frames_issued, "R10 no extra frames", cs_falls, frames_issued);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule